// File: doc/BRIEF.md
# Two-Wire Register Slave with Auto-Incrementing Pointer

This block is a two-wire (I2C) slave that gives a bus master access to a 64-byte register space. Locations 0 to 6 hold the timekeeping registers, location 7 is the control byte, and locations 8 to 63 are general-purpose storage. The storage itself sits outside the block and is reached through a simple synchronous register port. That port has a pointer-driven address, a one-cycle write strobe, write data and combinational read data.

The bus lines arrive as oversampled inputs. Each line passes through a synchronizer and a three-sample majority filter. After that, the block detects START, STOP and repeated START and matches the fixed 7-bit device address 0x68. In a write transfer, the first byte after the address loads the pointer. Every byte after that is stored at the pointer, and the pointer then advances. In a read transfer, the slave sends bytes from the pointer and advances the pointer only when the master acknowledges. The pointer is kept between transfers, so a read that does not first set an address continues from the last position.

A power-fail input ends any transfer in progress, clears the pointer and makes the block ignore the bus while the input is high. Clock stretching is not supported.

Top module: `i2c_reg_slave`

## Requirements
- R1: After reset the SDA output enable is 0, the write strobe is 0 and the pointer (`reg_addr`) is 0.
- R2: A START is SDA falling while SCL is high, and a STOP is SDA rising while SCL is high. After a START, an address byte of 0xD0 (device 0x68, R/W bit = 0, write) or 0xD1 (R/W bit = 1, read) is acknowledged by driving SDA low during the ninth clock.
- R3: In a write transfer, the first byte after the address is acknowledged and its low 6 bits load the pointer. Bits 7:6 of that byte are ignored.
- R4: Each further byte in a write transfer is acknowledged and stored at the pointer with a write strobe exactly one cycle long. The pointer then increments at the end of the acknowledge clock.
- R5: In a read transfer, the byte at the pointer is sent MSB first. The pointer increments only when the master acknowledges, and the next byte follows.
- R6: After a master NACK the slave releases SDA and leaves the pointer unchanged. A read with no preceding word address starts at the current pointer.
- R7: An address byte other than 0xD0 or 0xD1 is not acknowledged. After it, SDA stays released and nothing is written until the next START.
- R8: The pointer wraps from 63 to 0.
- R9: While power-fail is high, the transfer is aborted, the pointer is 0, SDA is released, no write occurs and bus activity is ignored. Bus activity is also ignored after power-fail falls, until the next START.
- R10: A repeated START (START with no STOP before it) restarts the address phase, so a read can follow a pointer write within the same transfer.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that oversamples the bus |
| rst | input | 1 | Synchronous active-high reset |
| scl_in | input | 1 | Sampled SCL line |
| sda_in | input | 1 | Sampled SDA line (wired-AND bus value) |
| pwr_fail | input | 1 | Supply out of tolerance; aborts and blocks access |
| sda_oe | output | 1 | Open-drain enable: 1 pulls SDA low |
| reg_addr | output | 6 | Current pointer, used as the register address |
| reg_we | output | 1 | One-cycle write strobe |
| reg_wdata | output | 8 | Write data, valid with `reg_we` |
| reg_rdata | input | 8 | Read data for `reg_addr`, combinational |

## Verification
A table of single-byte write and read-back pairs covers the clock registers, the control byte and the RAM range. The table uses data values with mixed bit patterns, so a bit-order or shift error shows up as a wrong byte and is not hidden. A four-byte burst that starts at 62 tells a correct wrap to 0 apart from overflow into an illegal address. A read burst ending in a NACK, followed by a read with no word address, tells an increment on the acknowledge apart from an increment on every byte. A foreign address, a word byte with its upper bits set, and power-fail raised both during a byte and across a whole transfer each show that bus activity is ignored, with the result checked on the ack bits, the strobe and `reg_addr`.

// File: rtl/i2c_rs_pkg.sv
package i2c_rs_pkg;

  typedef enum logic [3:0] {
    S_IDLE,
    S_ADDR,
    S_AACK,
    S_WADDR,
    S_WAACK,
    S_WDATA,
    S_WDACK,
    S_RLOAD,
    S_RDATA,
    S_RACK
  } eng_state_t;

endpackage

// File: rtl/i2c_rs_filter.sv
module i2c_rs_filter #(
  parameter int SYNC_STAGES = 2,
  parameter int FILT_LEN    = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic dout
);
  localparam int CNT_W = $clog2(FILT_LEN + 1);

  logic [SYNC_STAGES-1:0] sync_q;
  logic [FILT_LEN-1:0]    win_q;
  logic [CNT_W-1:0]       ones;
  logic                   maj;

  always_comb begin
    ones = '0;
    for (int i = 0; i < FILT_LEN; i++) ones = ones + CNT_W'(win_q[i]);
    maj = (ones > CNT_W'(FILT_LEN / 2));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sync_q <= '1;
      win_q  <= '1;
      dout   <= 1'b1;
    end else begin
      sync_q <= {sync_q[SYNC_STAGES-2:0], din};
      win_q  <= {win_q[FILT_LEN-2:0], sync_q[SYNC_STAGES-1]};
      dout   <= maj;
    end
  end

  // R2: a full window of ones must yield a high filtered line
  p_filt_major_r2: assert property (@(posedge clk) disable iff (rst)
    (&win_q) |=> dout);

endmodule

// File: rtl/i2c_rs_cond.sv
module i2c_rs_cond (
  input  logic clk,
  input  logic rst,
  input  logic scl_f,
  input  logic sda_f,
  output logic start_o,
  output logic stop_o,
  output logic scl_rise,
  output logic scl_fall
);
  logic scl_q, sda_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_f;
      sda_q <= sda_f;
    end
  end

  assign start_o  = scl_f & scl_q & sda_q & ~sda_f;
  assign stop_o   = scl_f & scl_q & ~sda_q & sda_f;
  assign scl_rise = scl_f & ~scl_q;
  assign scl_fall = ~scl_f & scl_q;

  // R2: bus events are mutually exclusive
  p_event_excl_r2: assert property (@(posedge clk) disable iff (rst)
    $onehot0({start_o, stop_o, scl_rise, scl_fall}));

endmodule

// File: rtl/i2c_rs_engine.sv
module i2c_rs_engine
  import i2c_rs_pkg::*;
#(
  parameter int          ADDR_W   = 6,
  parameter int          DATA_W   = 8,
  parameter logic [6:0]  DEV_ADDR = 7'h68
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              pwr_fail,
  input  logic              start_i,
  input  logic              stop_i,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              sda_s,
  input  logic [DATA_W-1:0] reg_rdata,
  output logic              sda_oe,
  output logic [ADDR_W-1:0] reg_addr,
  output logic              reg_we,
  output logic [DATA_W-1:0] reg_wdata
);
  localparam int CNT_W = $clog2(DATA_W + 1);
  localparam logic [CNT_W-1:0] BITS = CNT_W'(DATA_W);

  eng_state_t        state;
  logic [ADDR_W-1:0] ptr;
  logic [CNT_W-1:0]  cnt;
  logic [DATA_W-1:0] shreg;
  logic [DATA_W-1:0] tx;
  logic              rw;
  logic              mack;

  assign reg_addr  = ptr;
  assign reg_wdata = shreg;

  always_ff @(posedge clk) begin
    if (rst) begin
      state  <= S_IDLE;
      ptr    <= '0;
      cnt    <= '0;
      shreg  <= '0;
      tx     <= '0;
      rw     <= 1'b0;
      mack   <= 1'b0;
      sda_oe <= 1'b0;
      reg_we <= 1'b0;
    end else begin
      reg_we <= 1'b0;
      if (pwr_fail) begin
        state  <= S_IDLE;
        ptr    <= '0;
        cnt    <= '0;
        sda_oe <= 1'b0;
      end else if (stop_i) begin
        state  <= S_IDLE;
        sda_oe <= 1'b0;
      end else if (start_i) begin
        state  <= S_ADDR;
        cnt    <= '0;
        sda_oe <= 1'b0;
      end else begin
        case (state)
          S_ADDR, S_WADDR, S_WDATA: begin
            if (scl_rise) begin
              shreg <= {shreg[DATA_W-2:0], sda_s};
              cnt   <= cnt + 1'b1;
            end else if (scl_fall && cnt == BITS) begin
              cnt <= '0;
              if (state == S_ADDR) begin
                if (shreg[DATA_W-1:1] == DEV_ADDR) begin
                  rw     <= shreg[0];
                  sda_oe <= 1'b1;
                  state  <= S_AACK;
                end else begin
                  state <= S_IDLE;
                end
              end else if (state == S_WADDR) begin
                sda_oe <= 1'b1;
                state  <= S_WAACK;
              end else begin
                sda_oe <= 1'b1;
                reg_we <= 1'b1;
                state  <= S_WDACK;
              end
            end
          end
          S_AACK: if (scl_fall) begin
            sda_oe <= 1'b0;
            state  <= rw ? S_RLOAD : S_WADDR;
          end
          S_WAACK: if (scl_fall) begin
            ptr    <= shreg[ADDR_W-1:0];
            sda_oe <= 1'b0;
            state  <= S_WDATA;
          end
          S_WDACK: if (scl_fall) begin
            ptr    <= ptr + 1'b1;
            sda_oe <= 1'b0;
            state  <= S_WDATA;
          end
          S_RLOAD: begin
            tx     <= reg_rdata;
            sda_oe <= ~reg_rdata[DATA_W-1];
            cnt    <= '0;
            state  <= S_RDATA;
          end
          S_RDATA: if (scl_fall) begin
            if (cnt == BITS - 1'b1) begin
              sda_oe <= 1'b0;
              cnt    <= '0;
              state  <= S_RACK;
            end else begin
              sda_oe <= ~tx[DATA_W-2];
              tx     <= {tx[DATA_W-2:0], tx[DATA_W-1]};
              cnt    <= cnt + 1'b1;
            end
          end
          S_RACK: begin
            if (scl_rise) mack <= ~sda_s;
            else if (scl_fall) begin
              if (mack) begin
                ptr   <= ptr + 1'b1;
                state <= S_RLOAD;
              end else begin
                state <= S_IDLE;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

  // R9: power-fail releases the bus, clears the pointer, blocks writes
  p_pf_abort_r9: assert property (@(posedge clk) disable iff (rst)
    pwr_fail |=> (!sda_oe && ptr == '0 && !reg_we));

  // R4: write strobe lasts a single cycle
  p_we_pulse_r4: assert property (@(posedge clk) disable iff (rst)
    reg_we |=> !reg_we);

  // R7: an idle (unaddressed) slave never pulls SDA
  p_idle_release_r7: assert property (@(posedge clk) disable iff (rst)
    (state == S_IDLE) |-> !sda_oe);

  // R8: outside a pointer load or power-fail, the pointer only steps by one (mod 64)
  p_ptr_step_r8: assert property (@(posedge clk) disable iff (rst)
    (!$stable(ptr) && $past(state) != S_WAACK && !$past(pwr_fail))
      |-> (ptr == $past(ptr) + 1'b1));

endmodule

// File: rtl/i2c_reg_slave.sv
module i2c_reg_slave #(
  parameter int         ADDR_W      = 6,
  parameter int         DATA_W      = 8,
  parameter logic [6:0] DEV_ADDR    = 7'h68,
  parameter int         SYNC_STAGES = 2,
  parameter int         FILT_LEN    = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              scl_in,
  input  logic              sda_in,
  input  logic              pwr_fail,
  output logic              sda_oe,
  output logic [ADDR_W-1:0] reg_addr,
  output logic              reg_we,
  output logic [DATA_W-1:0] reg_wdata,
  input  logic [DATA_W-1:0] reg_rdata
);
  localparam int LINES = 2;

  logic [LINES-1:0] raw_lines;
  logic [LINES-1:0] filt_lines;
  logic start_ev, stop_ev, rise_ev, fall_ev;

  assign raw_lines = {sda_in, scl_in};

  for (genvar i = 0; i < LINES; i++) begin : g_line
    i2c_rs_filter #(
      .SYNC_STAGES(SYNC_STAGES),
      .FILT_LEN   (FILT_LEN)
    ) u_filt (
      .clk (clk),
      .rst (rst),
      .din (raw_lines[i]),
      .dout(filt_lines[i])
    );
  end

  i2c_rs_cond u_cond (
    .clk     (clk),
    .rst     (rst),
    .scl_f   (filt_lines[0]),
    .sda_f   (filt_lines[1]),
    .start_o (start_ev),
    .stop_o  (stop_ev),
    .scl_rise(rise_ev),
    .scl_fall(fall_ev)
  );

  i2c_rs_engine #(
    .ADDR_W  (ADDR_W),
    .DATA_W  (DATA_W),
    .DEV_ADDR(DEV_ADDR)
  ) u_eng (
    .clk      (clk),
    .rst      (rst),
    .pwr_fail (pwr_fail),
    .start_i  (start_ev),
    .stop_i   (stop_ev),
    .scl_rise (rise_ev),
    .scl_fall (fall_ev),
    .sda_s    (filt_lines[1]),
    .reg_rdata(reg_rdata),
    .sda_oe   (sda_oe),
    .reg_addr (reg_addr),
    .reg_we   (reg_we),
    .reg_wdata(reg_wdata)
  );

endmodule

// File: tb/tb_i2c_reg_slave.sv
`timescale 1ns/1ps
module tb_i2c_reg_slave;
  localparam int H  = 20;
  localparam int WD = 150000;
  localparam logic [13:0] VECS [8] = '{
    {6'd0,  8'h59}, {6'd1,  8'hA6}, {6'd6,  8'h3C}, {6'd7,  8'h81},
    {6'd8,  8'h00}, {6'd33, 8'hFF}, {6'd47, 8'h5A}, {6'd63, 8'hC3}
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic scl_m = 1'b1, sda_m = 1'b1, pwr_fail = 1'b0;
  logic sda_oe, reg_we;
  logic [5:0] reg_addr;
  logic [7:0] reg_wdata, reg_rdata;
  logic sda_line;
  logic [7:0] mem [64];
  logic [7:0] exp_mem [64];
  int nchk = 0, nfail = 0, we_cnt = 0;

  always #5 clk = ~clk;

  assign sda_line  = sda_m & ~sda_oe;
  assign reg_rdata = mem[reg_addr];

  i2c_reg_slave dut (
    .clk(clk), .rst(rst), .scl_in(scl_m), .sda_in(sda_line),
    .pwr_fail(pwr_fail), .sda_oe(sda_oe), .reg_addr(reg_addr),
    .reg_we(reg_we), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata)
  );

  initial for (int i = 0; i < 64; i++) begin
    mem[i]     = 8'(i * 7 + 3);
    exp_mem[i] = 8'(i * 7 + 3);
  end

  always @(posedge clk) begin
    if (reg_we) begin
      mem[reg_addr] <= reg_wdata;
      we_cnt <= we_cnt + 1;
    end
  end

  task automatic report;
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start;
    sda_m = 1'b1; wait_clk(H);
    scl_m = 1'b1; wait_clk(H);
    sda_m = 1'b0; wait_clk(H);
    scl_m = 1'b0; wait_clk(H);
  endtask

  task automatic bus_stop;
    sda_m = 1'b0; wait_clk(H);
    scl_m = 1'b1; wait_clk(H);
    sda_m = 1'b1; wait_clk(H);
  endtask

  task automatic send_byte(input logic [7:0] b, output logic nak);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; wait_clk(H);
      scl_m = 1'b1; wait_clk(H);
      scl_m = 1'b0; wait_clk(2);
    end
    sda_m = 1'b1; wait_clk(H);
    scl_m = 1'b1; wait_clk(H / 2);
    nak = sda_line; wait_clk(H / 2);
    scl_m = 1'b0; wait_clk(2);
  endtask

  task automatic recv_byte(input logic mack, output logic [7:0] b);
    for (int i = 7; i >= 0; i--) begin
      sda_m = 1'b1; wait_clk(H);
      scl_m = 1'b1; wait_clk(H / 2);
      b[i] = sda_line; wait_clk(H / 2);
      scl_m = 1'b0; wait_clk(2);
    end
    sda_m = ~mack; wait_clk(H);
    scl_m = 1'b1; wait_clk(H);
    scl_m = 1'b0; wait_clk(2);
    sda_m = 1'b1;
  endtask

  initial begin
    repeat (WD) @(posedge clk);
    nfail++;
    $display("FAIL watchdog: actual timeout expected completion");
    report();
    $finish;
  end

  initial begin
    logic nak;
    logic [7:0] rb;
    int we_before;

    wait_clk(4);
    rst = 1'b0;
    wait_clk(4);
    chk("R1 sda_oe after reset", 32'(sda_oe), 0);
    chk("R1 reg_we after reset", 32'(reg_we), 0);
    chk("R1 pointer after reset", 32'(reg_addr), 0);

    // Table: write one byte, then read it back through a repeated START
    for (int v = 0; v < 8; v++) begin
      logic [5:0] a;
      logic [7:0] d;
      a = VECS[v][13:8];
      d = VECS[v][7:0];
      bus_start();
      send_byte(8'hD0, nak); chk("R2 write address ack", 32'(nak), 0);
      send_byte({2'b00, a}, nak); chk("R3 word address ack", 32'(nak), 0);
      send_byte(d, nak); chk("R4 data ack", 32'(nak), 0);
      exp_mem[a] = d;
      bus_stop();
      bus_start();
      send_byte(8'hD0, nak);
      send_byte({2'b00, a}, nak);
      bus_start();
      send_byte(8'hD1, nak); chk("R10 read address ack after repeated START", 32'(nak), 0);
      recv_byte(1'b0, rb);
      chk("R5 read-back byte", 32'(rb), 32'(exp_mem[a]));
      bus_stop();
    end

    // R3: upper two bits of the word address are ignored
    bus_start();
    send_byte(8'hD0, nak);
    send_byte(8'hC5, nak);
    wait_clk(4);
    chk("R3 pointer from low six bits", 32'(reg_addr), 5);
    bus_stop();

    // R8/R4: burst write across the top of the space
    bus_start();
    send_byte(8'hD0, nak);
    send_byte(8'd62, nak);
    for (int k = 0; k < 4; k++) begin
      send_byte(8'hA1 + 8'(k), nak);
      chk("R4 burst data ack", 32'(nak), 0);
      exp_mem[6'(62 + k)] = 8'hA1 + 8'(k);
    end
    bus_stop();
    chk("R8 pointer after wrapping burst", 32'(reg_addr), 2);
    chk("R8 byte written at 0 after wrap", 32'(mem[0]), 32'h A3);

    // R5/R6: burst read, last byte NACKed
    bus_start();
    send_byte(8'hD0, nak);
    send_byte(8'd62, nak);
    bus_start();
    send_byte(8'hD1, nak);
    for (int k = 0; k < 4; k++) begin
      recv_byte(k != 3, rb);
      chk("R5 burst read byte", 32'(rb), 32'(exp_mem[6'(62 + k)]));
    end
    wait_clk(4);
    chk("R6 SDA released after master NACK", 32'(sda_oe), 0);
    bus_stop();
    chk("R6 pointer not advanced by NACK", 32'(reg_addr), 1);

    // R6: current-address read, no word address
    bus_start();
    send_byte(8'hD1, nak);
    chk("R6 current read address ack", 32'(nak), 0);
    recv_byte(1'b0, rb);
    chk("R6 current-address read byte", 32'(rb), 32'(exp_mem[1]));
    bus_stop();

    // R7: foreign device address
    we_before = we_cnt;
    bus_start();
    send_byte(8'hA0, nak);
    chk("R7 foreign address not acked", 32'(nak), 1);
    send_byte(8'h03, nak);
    chk("R7 following byte not acked", 32'(nak), 1);
    chk("R7 SDA released", 32'(sda_oe), 0);
    bus_stop();
    chk("R7 no write for foreign address", 32'(we_cnt), 32'(we_before));

    // R9: power-fail in the middle of a data byte
    we_before = we_cnt;
    bus_start();
    send_byte(8'hD0, nak);
    send_byte(8'h10, nak);
    for (int i = 7; i >= 4; i--) begin
      sda_m = 1'b0; wait_clk(H);
      scl_m = 1'b1; wait_clk(H);
      scl_m = 1'b0; wait_clk(2);
    end
    pwr_fail = 1'b1;
    wait_clk(3);
    chk("R9 pointer cleared by power-fail", 32'(reg_addr), 0);
    chk("R9 SDA released by power-fail", 32'(sda_oe), 0);
    for (int i = 3; i >= 0; i--) begin
      sda_m = 1'b0; wait_clk(H);
      scl_m = 1'b1; wait_clk(H);
      scl_m = 1'b0; wait_clk(2);
    end
    sda_m = 1'b1; wait_clk(H);
    scl_m = 1'b1; wait_clk(H / 2);
    chk("R9 aborted byte not acked", 32'(sda_line), 1);
    wait_clk(H / 2);
    scl_m = 1'b0; wait_clk(2);
    pwr_fail = 1'b0;
    send_byte(8'h77, nak);
    chk("R9 bus ignored until next START", 32'(nak), 1);
    bus_stop();
    chk("R9 no write after abort", 32'(we_cnt), 32'(we_before));

    // R9: full transfer while power-fail is held
    pwr_fail = 1'b1;
    bus_start();
    send_byte(8'hD0, nak);
    chk("R9 address ignored under power-fail", 32'(nak), 1);
    send_byte(8'h05, nak);
    send_byte(8'hEE, nak);
    bus_stop();
    chk("R9 no write under power-fail", 32'(we_cnt), 32'(we_before));
    chk("R9 pointer held at zero", 32'(reg_addr), 0);
    pwr_fail = 1'b0;
    wait_clk(4);

    // R1/R2: normal access resumes
    bus_start();
    send_byte(8'hD1, nak);
    chk("R2 access resumes after power-fail", 32'(nak), 0);
    recv_byte(1'b0, rb);
    chk("R6 read from cleared pointer", 32'(rb), 32'(exp_mem[0]));
    bus_stop();

    report();
    $finish;
  end

endmodule